// File: doc/BRIEF.md
# AC-link reset and power controller

This block is the controller side of the reset and power handling for an AC'97-style audio link to an external codec. It turns software control bits into a cold reset (the active-low reset pin held low for a minimum time) and a warm reset (a sync pulse sent while the codec's bit clock is stopped). It keeps the link pins at defined levels during platform reset and the system sleep states. It also watches the returning bit clock and the data-in lines, so it can report that the clock is running and flag a wake-up request from the codec.

Pulse lengths are counted in system clocks. The count comes from a clock-frequency parameter and a pulse-length parameter in microseconds. With the defaults (250 MHz, 1 µs), one pulse is 250 cycles. Frame slot formatting is done elsewhere. The frame engine's sync and data-out bits enter on `frame_sync` and `frame_sdout`, and this block gates them onto the pins.

The sleep state input uses this encoding: 0 = S0 (running), 1 = S1, 2 = S3, 3 = S4/S5.

Top module: `aclink_pwr_ctl`

## Requirements
- R1: A cycle with `rst` high makes `link_rst_n`, `link_sync` and `link_sdout` low on the next cycle. It also clears `pd_en`, every status bit and `irq`.
- R2: Each low period of `link_rst_n` lasts at least PULSE_CYC clocks (CLK_HZ/1e6 × PULSE_US; 250 by default). Clearing `sw_cold_n` for a single cycle while `link_rst_n` is high gives a low period of exactly 250 cycles.
- R3: While `sw_cold_n` is 0, `link_rst_n` is low from the next cycle on. Once `sw_cold_n` is 1 and the minimum time has passed, `link_rst_n` goes high on the next cycle.
- R4: When `sleep_st` is 2 (S3) or 3 (S4/S5), `link_rst_n` is low on the next cycle, whatever `sw_cold_n` holds.
- R5: When `sleep_st` is 1, 2 or 3, `link_sync` and `link_sdout` are low on the next cycle. In state 0 with no warm pulse running, they copy `frame_sync` and `frame_sdout` one cycle later.
- R6: `pd_en` copies `sw_link_off` with a latency of one cycle, so it is high only while the shut-off bit is set.
- R7: A one-cycle `sw_warm_req` is accepted when `st_bclk_run` is 0, `sleep_st` is 0 and `link_rst_n` is high. From the next cycle, `link_sync` is high for exactly PULSE_CYC cycles while `st_warm_busy` is high and `link_sdout` is low. After that, `st_warm_busy` clears by itself.
- R8: While a warm pulse holds `link_sync` high, `st_bclk_run` stays 0 even if the bit clock toggles. After the pulse ends, a toggling bit clock sets `st_bclk_run` within 10 cycles.
- R9: `st_bclk_run` is set within 6 cycles of a bit-clock toggle. It clears BCLK_TMO cycles (32 by default) after the last detected toggle.
- R10: A `sw_warm_req` made while `st_bclk_run` is 1 is ignored: `link_sync` stays low and `st_warm_err` is 1 on the next cycle. The next accepted warm request clears `st_warm_err`.
- R11: A rising edge on any `sdin` line while `st_bclk_run` is 0 sets `st_wake` within 4 cycles. `st_wake` stays set until a `sw_wake_clr` cycle, which clears it on the next cycle.
- R12: `irq` is `st_wake` gated by `sw_wake_ie`, both taken one cycle later. With `sw_wake_ie` at 0, `irq` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Platform reset, synchronous, active high |
| sleep_st | input | 2 | System sleep state: 0 S0, 1 S1, 2 S3, 3 S4/S5 |
| sw_cold_n | input | 1 | Software cold-reset bit; 0 holds the codec in reset |
| sw_warm_req | input | 1 | One-cycle strobe from a write of the warm-reset bit |
| sw_link_off | input | 1 | Link shut-off control bit |
| sw_wake_ie | input | 1 | Wake interrupt enable |
| sw_wake_clr | input | 1 | One-cycle strobe that clears the wake status |
| frame_sync | input | 1 | Sync bit from the frame engine |
| frame_sdout | input | 1 | Data-out bit from the frame engine |
| bclk_in | input | 1 | Bit clock returned by the codec |
| sdin | input | NSD | Data-in lines from the codecs |
| link_rst_n | output | 1 | Active-low codec reset pin |
| link_sync | output | 1 | Sync pin |
| link_sdout | output | 1 | Data-out pin |
| pd_en | output | 1 | Pull-down enable for the bit-clock and data-in lines |
| st_bclk_run | output | 1 | Status: bit clock detected as running |
| st_warm_busy | output | 1 | Status: warm reset pulse in progress |
| st_warm_err | output | 1 | Status: warm request refused because the bit clock was running |
| st_wake | output | 1 | Status: codec wake-up seen |
| irq | output | 1 | Wake interrupt |

## Verification
A bad cold-reset counter shows on `link_rst_n` as a low period of the wrong length. The bench measures that length to the cycle within one pulse time (about 250 cycles). A warm sequencer stuck busy or released early shows directly as a wrong count of `link_sync` high cycles. If the bit-clock mask is lost, `st_bclk_run` rises while sync is still high, within a few cycles of the codec starting its clock. Errors in the sleep gating or the wake latch appear on the pins or on `irq` on the cycle after the stimulus, so the sampled checks catch them at once.

// File: rtl/aclink_pkg.sv
package aclink_pkg;

    typedef enum logic [1:0] {
        SLP_S0  = 2'd0,
        SLP_S1  = 2'd1,
        SLP_S3  = 2'd2,
        SLP_S45 = 2'd3
    } sleep_e;

    typedef struct packed {
        logic sync;
        logic sdout;
        logic pd;
    } pin_drv_t;

    // Deep states hold the codec in reset.
    function automatic logic link_deep(input sleep_e s);
        return (s == SLP_S3) || (s == SLP_S45);
    endfunction

    // Any state other than running quiets the link.
    function automatic logic link_asleep(input sleep_e s);
        return s != SLP_S0;
    endfunction

    // Pulse length in clocks, never below two.
    function automatic int unsigned us_to_cycles(input int unsigned hz, input int unsigned us);
        int unsigned c;
        c = (hz / 1_000_000) * us;
        return (c < 2) ? 2 : c;
    endfunction

endpackage

// File: rtl/aclink_bclk_det.sv
module aclink_bclk_det #(
    parameter int unsigned TMO = 32
) (
    input  logic clk,
    input  logic rst,
    input  logic bclk_in,
    input  logic mask,
    output logic run
);
    localparam int unsigned CW = $clog2(TMO + 1);
    localparam logic [CW-1:0] LAST = CW'(TMO - 1);

    logic [2:0]    shr;       // [0],[1] synchronizer, [2] previous
    logic          toggled;
    logic [CW-1:0] idle_cnt;

    assign toggled = shr[1] ^ shr[2];

    always_ff @(posedge clk) begin
        if (rst) begin
            shr      <= '0;
            idle_cnt <= '0;
            run      <= 1'b0;
        end else begin
            shr <= {shr[1:0], bclk_in};
            if (mask) begin
                idle_cnt <= '0;
                run      <= 1'b0;
            end else if (toggled) begin
                idle_cnt <= '0;
                run      <= 1'b1;
            end else if (idle_cnt == LAST) begin
                run      <= 1'b0;
            end else begin
                idle_cnt <= idle_cnt + 1'b1;
            end
        end
    end

    AST_MASK_STOPS_RUN: assert property (@(posedge clk) disable iff (rst)
        mask |=> !run);  // R8

endmodule

// File: rtl/aclink_rst_seq.sv
module aclink_rst_seq
    import aclink_pkg::*;
#(
    parameter int unsigned PULSE_CYC = 250
) (
    input  logic   clk,
    input  logic   rst,
    input  sleep_e sleep,
    input  logic   sw_cold_n,
    input  logic   warm_req,
    input  logic   bclk_run,
    output logic   rst_n_q,
    output logic   warm_busy,
    output logic   warm_hold,
    output logic   warm_err
);
    localparam int unsigned CW = $clog2(PULSE_CYC);
    localparam logic [CW-1:0] LAST = CW'(PULSE_CYC - 1);

    logic [CW-1:0] cold_cnt, cold_cnt_d;
    logic [CW-1:0] warm_cnt;
    logic          force_low, rst_n_d, abort, accept;

    always_comb begin
        force_low  = link_deep(sleep) || !sw_cold_n;
        rst_n_d    = !force_low && (rst_n_q || (cold_cnt == LAST));
        cold_cnt_d = rst_n_q ? '0 : ((cold_cnt == LAST) ? cold_cnt : cold_cnt + 1'b1);
        abort      = link_asleep(sleep) || !rst_n_q;
        accept     = warm_req && !warm_busy && !bclk_run && !abort;
        warm_hold  = !abort && (accept || (warm_busy && (warm_cnt != LAST)));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rst_n_q   <= 1'b0;
            cold_cnt  <= '0;
            warm_busy <= 1'b0;
            warm_cnt  <= '0;
            warm_err  <= 1'b0;
        end else begin
            rst_n_q   <= rst_n_d;
            cold_cnt  <= cold_cnt_d;
            warm_busy <= warm_hold;
            warm_cnt  <= warm_busy ? warm_cnt + 1'b1 : '0;
            if (accept)
                warm_err <= 1'b0;
            else if (warm_req && bclk_run)
                warm_err <= 1'b1;
        end
    end

    AST_COLD_LEVEL: assert property (@(posedge clk) disable iff (rst)
        !sw_cold_n |=> !rst_n_q);  // R3
    AST_DEEP_HOLD: assert property (@(posedge clk) disable iff (rst)
        link_deep(sleep) |=> !rst_n_q);  // R4
    AST_WARM_REFUSED: assert property (@(posedge clk) disable iff (rst)
        (warm_req && bclk_run) |=> (warm_err && !warm_busy));  // R10

endmodule

// File: rtl/aclink_wake.sv
module aclink_wake #(
    parameter int unsigned NSD = 3
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [NSD-1:0] sdin,
    input  logic           bclk_run,
    input  logic           clr,
    input  logic           ie,
    output logic           wake,
    output logic           irq
);
    logic [NSD-1:0] rise_v;
    logic           wake_d;

    for (genvar g = 0; g < NSD; g++) begin : g_line
        logic [2:0] shr;  // [0],[1] synchronizer, [2] previous
        always_ff @(posedge clk) begin
            if (rst) shr <= '0;
            else     shr <= {shr[1:0], sdin[g]};
        end
        assign rise_v[g] = shr[1] && !shr[2];
    end

    assign wake_d = ((|rise_v) && !bclk_run) || (wake && !clr);

    always_ff @(posedge clk) begin
        if (rst) begin
            wake <= 1'b0;
            irq  <= 1'b0;
        end else begin
            wake <= wake_d;
            irq  <= wake_d && ie;
        end
    end

    AST_WAKE_STICKY: assert property (@(posedge clk) disable iff (rst)
        (wake && !clr) |=> wake);  // R11
    AST_IRQ_OFF: assert property (@(posedge clk) disable iff (rst)
        !ie |=> !irq);  // R12

endmodule

// File: rtl/aclink_pwr_ctl.sv
module aclink_pwr_ctl
    import aclink_pkg::*;
#(
    parameter int unsigned CLK_HZ   = 250_000_000,
    parameter int unsigned PULSE_US = 1,
    parameter int unsigned BCLK_TMO = 32,
    parameter int unsigned NSD      = 3
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [1:0]     sleep_st,
    input  logic           sw_cold_n,
    input  logic           sw_warm_req,
    input  logic           sw_link_off,
    input  logic           sw_wake_ie,
    input  logic           sw_wake_clr,
    input  logic           frame_sync,
    input  logic           frame_sdout,
    input  logic           bclk_in,
    input  logic [NSD-1:0] sdin,
    output logic           link_rst_n,
    output logic           link_sync,
    output logic           link_sdout,
    output logic           pd_en,
    output logic           st_bclk_run,
    output logic           st_warm_busy,
    output logic           st_warm_err,
    output logic           st_wake,
    output logic           irq
);
    localparam int unsigned PULSE_CYC = us_to_cycles(CLK_HZ, PULSE_US);

    sleep_e   slp;
    logic     warm_hold;
    pin_drv_t drv_q, drv_d;

    assign slp = sleep_e'(sleep_st);

    aclink_rst_seq #(.PULSE_CYC(PULSE_CYC)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .sleep     (slp),
        .sw_cold_n (sw_cold_n),
        .warm_req  (sw_warm_req),
        .bclk_run  (st_bclk_run),
        .rst_n_q   (link_rst_n),
        .warm_busy (st_warm_busy),
        .warm_hold (warm_hold),
        .warm_err  (st_warm_err)
    );

    aclink_bclk_det #(.TMO(BCLK_TMO)) u_bclk (
        .clk     (clk),
        .rst     (rst),
        .bclk_in (bclk_in),
        .mask    (warm_hold),
        .run     (st_bclk_run)
    );

    aclink_wake #(.NSD(NSD)) u_wake (
        .clk      (clk),
        .rst      (rst),
        .sdin     (sdin),
        .bclk_run (st_bclk_run),
        .clr      (sw_wake_clr),
        .ie       (sw_wake_ie),
        .wake     (st_wake),
        .irq      (irq)
    );

    always_comb begin
        drv_d.sync  = !link_asleep(slp) && (warm_hold || frame_sync);
        drv_d.sdout = !link_asleep(slp) && !warm_hold && frame_sdout;
        drv_d.pd    = sw_link_off;
    end

    always_ff @(posedge clk) begin
        if (rst) drv_q <= '0;
        else     drv_q <= drv_d;
    end

    assign link_sync  = drv_q.sync;
    assign link_sdout = drv_q.sdout;
    assign pd_en      = drv_q.pd;

    AST_PLAT_RST_LOW: assert property (@(posedge clk)
        rst |=> (!link_rst_n && !link_sync && !link_sdout));  // R1
    AST_SLEEP_QUIET: assert property (@(posedge clk) disable iff (rst)
        (sleep_st != 2'd0) |=> (!link_sync && !link_sdout));  // R5
    AST_PD_OFF: assert property (@(posedge clk) disable iff (rst)
        !sw_link_off |=> !pd_en);  // R6
    AST_NO_BCLK_IN_PULSE: assert property (@(posedge clk) disable iff (rst)
        (st_warm_busy && link_sync) |-> !st_bclk_run);  // R8
    AST_IRQ_NEEDS_WAKE: assert property (@(posedge clk) disable iff (rst)
        irq |-> st_wake);  // R12

endmodule

// File: tb/sim_aclink_pwr_ctl.sv
module sim_aclink_pwr_ctl;
    localparam int unsigned PULSE = 250;  // 1 us at 250 MHz
    localparam int unsigned TMO   = 32;

    logic       clk = 1'b0;
    logic       rst;
    logic [1:0] sleep_st;
    logic       sw_cold_n, sw_warm_req, sw_link_off, sw_wake_ie, sw_wake_clr;
    logic       frame_sync, frame_sdout;
    logic       bclk_in = 1'b0;
    logic       bclk_en = 1'b0;
    logic [2:0] sdin;
    logic       link_rst_n, link_sync, link_sdout, pd_en;
    logic       st_bclk_run, st_warm_busy, st_warm_err, st_wake, irq;

    int unsigned n_chk = 0;
    int unsigned n_bad = 0;
    bit          done  = 1'b0;

    always #2 clk = ~clk;
    always #16 if (bclk_en) bclk_in = ~bclk_in;

    aclink_pwr_ctl u0 (
        .clk(clk), .rst(rst), .sleep_st(sleep_st), .sw_cold_n(sw_cold_n),
        .sw_warm_req(sw_warm_req), .sw_link_off(sw_link_off), .sw_wake_ie(sw_wake_ie),
        .sw_wake_clr(sw_wake_clr), .frame_sync(frame_sync), .frame_sdout(frame_sdout),
        .bclk_in(bclk_in), .sdin(sdin), .link_rst_n(link_rst_n), .link_sync(link_sync),
        .link_sdout(link_sdout), .pd_en(pd_en), .st_bclk_run(st_bclk_run),
        .st_warm_busy(st_warm_busy), .st_warm_err(st_warm_err), .st_wake(st_wake), .irq(irq)
    );

    function automatic logic exp_sync(input logic [1:0] s, input logic fs);
        return (s == 2'd0) && fs;
    endfunction
    function automatic logic exp_sdout(input logic [1:0] s, input logic fd);
        return (s == 2'd0) && fd;
    endfunction

    task automatic check(input string req, input int unsigned act, input int unsigned exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    initial begin
        #(4 * 150000);
        if (!done) begin
            n_bad++;
            n_chk++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        int unsigned n, bad;
        void'($urandom(32'h1ac5));
        rst = 1'b1; sleep_st = 2'd0; sw_cold_n = 1'b0; sw_warm_req = 1'b0;
        sw_link_off = 1'b1; sw_wake_ie = 1'b1; sw_wake_clr = 1'b0;
        frame_sync = 1'b1; frame_sdout = 1'b1; sdin = '0;
        repeat (3) tick();
        // R1 reset state
        check("R1 rst_n", link_rst_n, 0);
        check("R1 sync", link_sync, 0);
        check("R1 sdout", link_sdout, 0);
        check("R1 pd_en", pd_en, 0);
        check("R1 status", {st_bclk_run, st_warm_busy, st_warm_err, st_wake, irq}, 0);
        rst = 1'b0; sw_link_off = 1'b0; sw_wake_ie = 1'b0;
        frame_sync = 1'b0; frame_sdout = 1'b0; sw_cold_n = 1'b1;
        repeat (PULSE + 5) tick();
        check("R3 released", link_rst_n, 1);

        // R2 single-cycle clear gives exactly the minimum pulse
        sw_cold_n = 1'b0; tick(); sw_cold_n = 1'b1;
        n = 0;
        while (!link_rst_n && n < 1000) begin n++; tick(); end
        check("R2 low cycles", n, PULSE);

        // R3 level-held cold reset
        sw_cold_n = 1'b0; bad = 0;
        repeat (400) begin tick(); if (link_rst_n) bad++; end
        check("R3 held low", bad, 0);
        sw_cold_n = 1'b1; tick();
        check("R3 release", link_rst_n, 1);

        // R4 deep sleep overrides software
        sleep_st = 2'd2; frame_sync = 1'b1; frame_sdout = 1'b1; tick();
        check("R4 S3 low", link_rst_n, 0);
        check("R5 S3 sync", link_sync, 0);
        bad = 0;
        repeat (300) begin tick(); if (link_rst_n) bad++; end
        sleep_st = 2'd3;
        repeat (20) begin tick(); if (link_rst_n) bad++; end
        check("R4 held through S3/S45", bad, 0);
        sleep_st = 2'd0; repeat (3) tick();
        check("R4 resume", link_rst_n, 1);

        // R5 S1 quiets the link, reset stays high
        sleep_st = 2'd1; tick();
        check("R5 S1 sync", link_sync, 0);
        check("R5 S1 sdout", link_sdout, 0);
        check("R5 S1 rst_n", link_rst_n, 1);
        sleep_st = 2'd0; tick();
        check("R5 S0 sync", link_sync, 1);
        check("R5 S0 sdout", link_sdout, 1);

        // R5 R6 random gating
        for (int i = 0; i < 3000; i++) begin
            logic [1:0] s;
            logic fs, fd, lo;
            logic [31:0] r;
            r = $urandom;
            s = r[1:0]; fs = r[2]; fd = r[3]; lo = r[4];
            sleep_st = s; frame_sync = fs; frame_sdout = fd; sw_link_off = lo;
            tick();
            check("R5 rand sync", link_sync, exp_sync(s, fs));
            check("R5 rand sdout", link_sdout, exp_sdout(s, fd));
            check("R6 rand pd_en", pd_en, lo);
        end
        sleep_st = 2'd0; frame_sync = 1'b0; frame_sdout = 1'b0; sw_link_off = 1'b0;
        repeat (PULSE + 5) tick();
        check("R3 up after random", link_rst_n, 1);
        check("R9 idle", st_bclk_run, 0);

        // R7 R8 warm pulse; codec clock starts too early mid-pulse
        frame_sdout = 1'b1;
        sw_warm_req = 1'b1; tick(); sw_warm_req = 1'b0;
        check("R7 busy", st_warm_busy, 1);
        n = 0; bad = 0;
        while (link_sync && n < 1000) begin
            n++;
            if (st_bclk_run || link_sdout) bad++;
            if (n == 100) bclk_en = 1'b1;
            tick();
        end
        frame_sdout = 1'b0;
        check("R7 sync high cycles", n, PULSE);
        check("R8 no run during pulse", bad, 0);
        check("R7 self clear", st_warm_busy, 0);
        n = 0;
        while (!st_bclk_run && n < 20) begin n++; tick(); end
        check("R8 run after sync low", (n <= 10) ? 1 : 0, 1);

        // R10 request while clock runs
        sw_warm_req = 1'b1; tick(); sw_warm_req = 1'b0;
        check("R10 err", st_warm_err, 1);
        bad = 0;
        repeat (20) begin if (link_sync || st_warm_busy) bad++; tick(); end
        check("R10 ignored", bad, 0);

        // R9 timeout
        bclk_en = 1'b0; n = 0;
        while (st_bclk_run && n < 200) begin n++; tick(); end
        check("R9 timeout window", (n >= TMO - 4 && n <= TMO + 4) ? 1 : 0, 1);

        // R10 accepted request clears error
        sw_warm_req = 1'b1; tick(); sw_warm_req = 1'b0;
        check("R10 err clear", st_warm_err, 0);
        check("R7 second pulse", link_sync, 1);
        while (st_warm_busy) tick();

        // R11 R12 wake
        sw_wake_ie = 1'b0; sdin = 3'b010;
        repeat (4) tick();
        check("R11 wake set", st_wake, 1);
        check("R12 masked", irq, 0);
        sw_wake_ie = 1'b1; tick();
        check("R12 irq", irq, 1);
        sw_wake_clr = 1'b1; tick(); sw_wake_clr = 1'b0;
        check("R11 clear", st_wake, 0);
        check("R12 irq clear", irq, 0);
        repeat (5) tick();
        check("R11 stays clear", st_wake, 0);
        sdin = 3'b110; repeat (4) tick();
        check("R11 second line", st_wake, 1);
        check("R12 irq again", irq, 1);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule